// File: doc/BRIEF.md
# GPU Command Packet Framer

The framer takes a stream of 32-bit graphics command words and cuts it into whole command packets. The opcode in the top byte of each packet's first word selects how the packet ends. Most opcodes have a fixed word count. Line-strip opcodes run until a terminator word appears at one of the checked positions. Image-transfer and area-copy headers get a tag of their own. Environment-setting words never reach the output: they are written into an eight-entry register file, and the low bits of a status word mirror fields of that file.

A packet reaches the output only once every one of its words is in. Words are collected in a packet buffer that has a commit pointer. Committed packets keep draining to the consumer while the next packet is still arriving. After a transfer header that writes into video memory, the framer stops decoding. It passes the pixel words through as data until the number of words implied by the transfer size has gone by, then decodes again. Each output word carries a two-bit kind tag and a last-word flag, so a downstream transfer engine can take its own headers and pixel data off the same stream.

Top module: `gpu_pkt_framer`

## Requirements
- R1: During reset and after it, out_valid_o is 0 and in_ready_o is 1. Environment register i reads back (0xE0+i)<<24, and status_o is 0x14802000.
- R2: Any opcode (bits 31:24 of a packet's first word) that is not a line strip, copy, transfer or environment opcode gives a packet with a fixed number of words after the header. The count is 2 for 0x02. In 0x20-0x3F it follows opcode bits 4:2: 3,6,4,8,5,8,7,11. It is 2 for 0x40-0x47 and 3 for 0x50-0x57. In 0x60-0x7F it follows opcode bits 4:2: 2,3,1,0,1,2,1,2. Every other opcode, 0xE8-0xFF included, has 0 words after the header. These packets carry kind 0, and last is set on the final word only.
- R3: Opcodes 0x48-0x4F are flat line strips. The word with index k (header = 0) ends the packet if k >= 3 and (word & 0xF000F000) == 0x50005000. Words with index 1 and 2 never end it. Kind is 0.
- R4: Opcodes 0x58-0x5F are shaded line strips. Only even word indices from 4 upward are tested against the same terminator. A matching word at an odd index, or at an index below 4, does not end the packet.
- R5: Opcodes 0x80-0x9F are copies of four words in total, with kind 1 and last on the fourth word.
- R6: Opcodes 0xA0-0xBF (write) and 0xC0-0xDF (read) are three-word transfer headers (header, position, size), with kind 2 and last on the size word. After a read header, the next word is decoded as a new packet.
- R7: After a write header, the next ceil(W*H/2) words are forwarded unchanged with kind 3, and last is set on the final one. W is ((size[9:0]-1) mod 1024)+1 and H is ((size[24:16]-1) mod 512)+1, so a zero field means 1024 or 512. Other size bits are ignored. Pixel words are never decoded, so a pixel word that looks like an environment opcode changes no register and no status bit.
- R8: Opcodes 0xE0-0xE7 write the whole word into environment register (opcode & 7) and produce no output word.
- R9: status_o[10:0] equals environment register 1 bits 10:0. status_o[12:11] equals environment register 6 bits 1:0. Bits 31:13 stay at 0x14802000's value. Register and status updates are visible the cycle after the word is accepted.
- R10: A packet's first word becomes visible on the output no sooner than the cycle after its last word is accepted, and exactly then if the buffer ahead of it is empty. A packet that is only partly received does not hold back complete packets ahead of it.
- R11: Output words keep input order with none lost or repeated under any out_ready_i pattern. in_ready_o drops only when the buffer holds DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Command word valid |
| in_data_i | input | 32 | Command word |
| in_ready_o | output | 1 | Framer can accept a word |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output word |
| out_kind_o | output | 2 | 0 draw, 1 copy, 2 transfer header, 3 pixel data |
| out_last_o | output | 1 | Final word of a packet or transfer |
| out_ready_i | input | 1 | Consumer accepts the output word |
| env_idx_i | input | 3 | Environment register read select |
| env_data_o | output | 32 | Selected environment register |
| status_o | output | 32 | Status word with mirrored environment fields |

## Verification
A packet's last word is written together with a commit, so the earliest it can appear on the output is the cycle after the accepting edge. Register and status updates follow the same one-edge latency. The bench drives inputs and samples outputs on the falling edge, so every sample sees the state that the preceding rising edge produced. Output order is checked with a scoreboard queue filled before each word is sent. Those comparisons therefore do not depend on latency and hold under random stalls. Directed steps check the exact cycle of the partial-packet hold, the release and the buffer-full boundary at chosen falling edges.

// File: rtl/gpu_pkt_pkg.sv
package gpu_pkt_pkg;
  localparam int WORD_W = 32;
  localparam int XW     = 10;
  localparam int YW     = 9;
  localparam int PIXW   = XW + YW + 1;
  localparam int LEN_W  = 4;
  localparam int ENV_N  = 8;
  localparam int ENV_AW = $clog2(ENV_N);
  localparam logic [WORD_W-1:0] STATUS_RST = 32'h1480_2000;

  typedef enum logic [1:0] {K_DRAW = 2'd0, K_COPY = 2'd1, K_XHDR = 2'd2, K_PIX = 2'd3} kind_e;
  typedef enum logic [2:0] {C_FIXED, C_POLY_F, C_POLY_S, C_COPY, C_XFER, C_ENV} cls_e;

  typedef struct packed {
    kind_e             kind;
    logic              last;
    logic [WORD_W-1:0] data;
  } ent_t;

  function automatic logic [LEN_W-1:0] fixed_len(input logic [7:0] op);
    logic [LEN_W-1:0] r;
    unique case (op[7:5])
      3'd0: r = (op == 8'h02) ? 4'd2 : 4'd0;
      3'd1: case (op[4:2])
              3'd0: r = 4'd3;  3'd1: r = 4'd6;  3'd2: r = 4'd4;  3'd3: r = 4'd8;
              3'd4: r = 4'd5;  3'd5: r = 4'd8;  3'd6: r = 4'd7;  default: r = 4'd11;
            endcase
      3'd2: r = op[4] ? 4'd3 : 4'd2;
      3'd3: case (op[4:2])
              3'd0: r = 4'd2;  3'd1: r = 4'd3;  3'd2: r = 4'd1;  3'd3: r = 4'd0;
              3'd4: r = 4'd1;  3'd5: r = 4'd2;  3'd6: r = 4'd1;  default: r = 4'd2;
            endcase
      default: r = 4'd0;
    endcase
    return r;
  endfunction

  // words of pixel data implied by a transfer size word (two pixels per word)
  function automatic logic [PIXW-1:0] xfer_words(input logic [WORD_W-1:0] sz);
    logic [XW-1:0]      wm;
    logic [YW-1:0]      hm;
    logic [XW:0]        w;
    logic [YW:0]        h;
    logic [PIXW:0]      p;
    wm = sz[XW-1:0] - XW'(1);
    hm = sz[16+YW-1:16] - YW'(1);
    w  = {1'b0, wm} + (XW+1)'(1);
    h  = {1'b0, hm} + (YW+1)'(1);
    p  = {{(YW+1){1'b0}}, w} * {{(XW+1){1'b0}}, h};
    p  = p + (PIXW+1)'(1);
    return p[PIXW:1];
  endfunction
endpackage

// File: rtl/gpu_cmd_dec.sv
module gpu_cmd_dec
  import gpu_pkt_pkg::*;
(
  input  logic [7:0]       op_i,
  output cls_e             cls_o,
  output logic [LEN_W-1:0] len_o,
  output logic             xwr_o
);
  always_comb begin
    len_o = fixed_len(op_i);
    xwr_o = (op_i[7:5] == 3'b101);
    if (op_i[7:3] == 5'b11100)                          cls_o = C_ENV;
    else if (op_i[7:5] == 3'b101 || op_i[7:5] == 3'b110) cls_o = C_XFER;
    else if (op_i[7:5] == 3'b100)                        cls_o = C_COPY;
    else if (op_i[7:3] == 5'b01001)                      cls_o = C_POLY_F;
    else if (op_i[7:3] == 5'b01011)                      cls_o = C_POLY_S;
    else                                                 cls_o = C_FIXED;
  end
endmodule

// File: rtl/gpu_pkt_fifo.sv
module gpu_pkt_fifo
  import gpu_pkt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic commit_i,
  input  ent_t wdata_i,
  output logic full_o,
  input  logic rd_ready_i,
  output logic rd_valid_o,
  output ent_t rdata_o
);
  localparam int AW = $clog2(DEPTH);

  ent_t        mem_q [DEPTH];
  logic [AW:0] wptr_q, cptr_q, rptr_q;

  assign full_o     = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign rd_valid_o = (rptr_q != cptr_q);
  assign rdata_o    = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wptr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_i) wptr_q <= wptr_q + 1'b1;
      // committing write publishes everything up to and including itself
      if (wr_i && commit_i) cptr_q <= wptr_q + 1'b1;
      if (rd_valid_o && rd_ready_i) rptr_q <= rptr_q + 1'b1;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_i |-> !full_o);
  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rdata_o));
  // R10
  rise_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(wr_i && commit_i));
endmodule

// File: rtl/gpu_env_regs.sv
module gpu_env_regs
  import gpu_pkt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ENV_AW-1:0] idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ENV_AW-1:0] rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [WORD_W-1:0] status_o
);
  logic [WORD_W-1:0] env_q [ENV_N];

  for (genvar i = 0; i < ENV_N; i++) begin : g_env
    localparam logic [7:0] RST_OP = 8'hE0 + 8'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           env_q[i] <= {RST_OP, {(WORD_W-8){1'b0}}};
      else if (we_i && idx_i == ENV_AW'(i))  env_q[i] <= wdata_i;
    end
  end

  assign rd_data_o = env_q[rd_idx_i];
  assign status_o  = {STATUS_RST[WORD_W-1:13], env_q[6][1:0], env_q[1][10:0]};

  // R9
  env1_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && idx_i == ENV_AW'(1) |=> status_o[10:0] == $past(wdata_i[10:0]));
  // R9
  env6_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && idx_i == ENV_AW'(6) |=> status_o[12:11] == $past(wdata_i[1:0]));
endmodule

// File: rtl/gpu_pkt_framer.sv
module gpu_pkt_framer
  import gpu_pkt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [31:0] in_data_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  output logic [31:0] out_data_o,
  output logic [1:0]  out_kind_o,
  output logic        out_last_o,
  input  logic        out_ready_i,
  input  logic [2:0]  env_idx_i,
  output logic [31:0] env_data_o,
  output logic [31:0] status_o
);
  localparam int IDX_W = $clog2(DEPTH) + 1;

  typedef enum logic [1:0] {S_HDR, S_BODY, S_POLY, S_PIX} st_e;

  st_e              state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PIXW-1:0]  pix_q, pix_d;
  kind_e            kind_q, kind_d;
  logic             xwr_q, xwr_d, shd_q, shd_d;

  cls_e             dec_cls;
  logic [LEN_W-1:0] dec_len;
  logic             dec_xwr;
  logic             full, acc, fifo_wr, commit, env_we, wlast, chk, term;
  kind_e            wkind;
  ent_t             wr_ent, rd_ent;

  gpu_cmd_dec u_dec (
    .op_i  (in_data_i[31:24]),
    .cls_o (dec_cls),
    .len_o (dec_len),
    .xwr_o (dec_xwr)
  );

  assign in_ready_o = !full;
  assign acc        = in_valid_i && in_ready_o;
  assign term       = (in_data_i & 32'hF000_F000) == 32'h5000_5000;

  always_comb begin
    state_d = state_q;  rem_d = rem_q;  idx_d = idx_q;  pix_d = pix_q;
    kind_d  = kind_q;   xwr_d = xwr_q;  shd_d = shd_q;
    fifo_wr = 1'b0;     env_we = 1'b0;  wlast = 1'b0;   wkind = K_DRAW;
    commit  = 1'b0;     chk = 1'b0;
    if (acc) begin
      unique case (state_q)
        S_HDR: begin
          unique case (dec_cls)
            C_ENV: env_we = 1'b1;
            C_FIXED: begin
              fifo_wr = 1'b1;
              kind_d  = K_DRAW;
              rem_d   = dec_len;
              if (dec_len == '0) wlast = 1'b1;
              else               state_d = S_BODY;
            end
            C_COPY: begin
              fifo_wr = 1'b1;  wkind = K_COPY;  kind_d = K_COPY;
              rem_d   = LEN_W'(3);  state_d = S_BODY;
            end
            C_XFER: begin
              fifo_wr = 1'b1;  wkind = K_XHDR;  kind_d = K_XHDR;
              rem_d   = LEN_W'(2);  xwr_d = dec_xwr;  state_d = S_BODY;
            end
            default: begin
              fifo_wr = 1'b1;
              shd_d   = (dec_cls == C_POLY_S);
              idx_d   = IDX_W'(1);
              state_d = S_POLY;
            end
          endcase
        end
        S_BODY: begin
          fifo_wr = 1'b1;
          wkind   = kind_q;
          wlast   = (rem_q == LEN_W'(1));
          rem_d   = rem_q - LEN_W'(1);
          if (wlast) begin
            if (kind_q == K_XHDR && xwr_q) begin
              pix_d   = xfer_words(in_data_i);
              state_d = S_PIX;
            end else begin
              state_d = S_HDR;
            end
          end
        end
        S_POLY: begin
          fifo_wr = 1'b1;
          chk     = shd_q ? (idx_q >= IDX_W'(4) && !idx_q[0]) : (idx_q >= IDX_W'(3));
          wlast   = chk && term;
          idx_d   = idx_q + IDX_W'(1);
          if (wlast) state_d = S_HDR;
        end
        default: begin
          fifo_wr = 1'b1;
          wkind   = K_PIX;
          commit  = 1'b1;
          wlast   = (pix_q == PIXW'(1));
          pix_d   = pix_q - PIXW'(1);
          if (wlast) state_d = S_HDR;
        end
      endcase
    end
    commit = commit || (fifo_wr && wlast);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HDR;  rem_q <= '0;  idx_q <= '0;  pix_q <= '0;
      kind_q  <= K_DRAW; xwr_q <= 1'b0; shd_q <= 1'b0;
    end else begin
      state_q <= state_d;  rem_q <= rem_d;  idx_q <= idx_d;  pix_q <= pix_d;
      kind_q  <= kind_d;   xwr_q <= xwr_d;  shd_q <= shd_d;
    end
  end

  assign wr_ent = '{kind: wkind, last: wlast, data: in_data_i};

  gpu_pkt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (fifo_wr),
    .commit_i   (commit),
    .wdata_i    (wr_ent),
    .full_o     (full),
    .rd_ready_i (out_ready_i),
    .rd_valid_o (out_valid_o),
    .rdata_o    (rd_ent)
  );

  assign out_data_o = rd_ent.data;
  assign out_kind_o = rd_ent.kind;
  assign out_last_o = rd_ent.last;

  gpu_env_regs u_env (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (env_we),
    .idx_i     (in_data_i[26:24]),
    .wdata_i   (in_data_i),
    .rd_idx_i  (env_idx_i),
    .rd_data_o (env_data_o),
    .status_o  (status_o)
  );

  // R7
  pix_no_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_PIX |=> $stable(status_o));
endmodule

// File: tb/tb_gpu_pkt_framer.sv
`timescale 1ns/1ps
module tb_gpu_pkt_framer;
  localparam int DEPTH = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid, out_last, out_ready;
  logic [31:0] out_data, env_data, status;
  logic [1:0]  out_kind;
  logic [2:0]  env_idx = '0;

  int errors = 0, checks = 0;
  int mode = 1;  // 0 random ready, 1 always ready, 2 never ready
  logic [34:0] exp_q[$];
  string       req_q[$];
  logic [31:0] env_m [8];

  always #5 clk = ~clk;

  gpu_pkt_framer #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_kind_o(out_kind), .out_last_o(out_last), .out_ready_i(out_ready),
    .env_idx_i(env_idx), .env_data_o(env_data), .status_o(status)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // consumer: decide ready at the falling edge, record the word that transfers at the next rise
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : ($urandom % 4 != 0);
      if (rst_n && out_ready && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected word", {29'd0, out_kind, out_last, out_data}, 0);
        end else begin
          logic [34:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check({out_kind, out_last, out_data} == e, r, {out_kind, out_last, out_data}, e);
        end
      end
    end
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int exp_len(input logic [7:0] op);
    if (op == 8'h02) return 2;
    if (op inside {[8'h20:8'h23]}) return 3;
    if (op inside {[8'h24:8'h27], [8'h2C:8'h2F], [8'h34:8'h37]}) return (op inside {[8'h24:8'h27]}) ? 6 : 8;
    if (op inside {[8'h28:8'h2B]}) return 4;
    if (op inside {[8'h30:8'h33]}) return 5;
    if (op inside {[8'h38:8'h3B]}) return 7;
    if (op inside {[8'h3C:8'h3F]}) return 11;
    if (op inside {[8'h40:8'h47], [8'h60:8'h63], [8'h74:8'h77], [8'h7C:8'h7F]}) return 2;
    if (op inside {[8'h50:8'h57], [8'h64:8'h67]}) return 3;
    if (op inside {[8'h68:8'h6B], [8'h70:8'h73], [8'h78:8'h7B]}) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mk_term();
    return ($urandom & 32'h0FFF_0FFF) | 32'h5000_5000;
  endfunction

  function automatic logic [31:0] non_term();
    logic [31:0] w = $urandom;
    if ((w & 32'hF000_F000) == 32'h5000_5000) w ^= 32'h1000_0000;
    return w;
  endfunction

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sx(input logic [31:0] d, input logic [1:0] k, input bit l, input string r);
    exp_q.push_back({k, l, d});
    req_q.push_back(r);
    send(d);
  endtask

  task automatic pkt_fixed(input logic [7:0] op);
    int n = exp_len(op);
    sx({op, 24'($urandom)}, 2'd0, n == 0, "R2");
    for (int i = 1; i <= n; i++) sx($urandom, 2'd0, i == n, "R2");
  endtask

  task automatic pkt_poly(input bit shaded, input int k);
    string r = shaded ? "R4" : "R3";
    logic [7:0] op = shaded ? (8'h58 | 8'($urandom % 8)) : (8'h48 | 8'($urandom % 8));
    sx({op, 24'($urandom)}, 2'd0, 1'b0, r);
    for (int i = 1; i <= k; i++) begin
      logic [31:0] d;
      bit checked = shaded ? (i >= 4 && i % 2 == 0) : (i >= 3);
      if (i == k)       d = mk_term();
      else if (checked) d = non_term();
      else              d = ($urandom % 2) ? mk_term() : $urandom;
      sx(d, 2'd0, i == k, r);
    end
  endtask

  task automatic pkt_copy();
    sx({8'h80 | 8'($urandom % 32), 24'($urandom)}, 2'd1, 1'b0, "R5");
    for (int i = 1; i <= 3; i++) sx($urandom, 2'd1, i == 3, "R5");
  endtask

  task automatic pkt_xfer(input bit wr, input logic [31:0] size);
    int wf, hf, n;
    logic [7:0] op = wr ? (8'hA0 | 8'($urandom % 32)) : (8'hC0 | 8'($urandom % 32));
    sx({op, 24'($urandom)}, 2'd2, 1'b0, "R6");
    sx($urandom, 2'd2, 1'b0, "R6");
    sx(size, 2'd2, 1'b1, "R6");
    if (wr) begin
      wf = (size[9:0] == 0) ? 1024 : int'(size[9:0]);
      hf = (size[24:16] == 0) ? 512 : int'(size[24:16]);
      n  = (wf * hf + 1) / 2;
      for (int i = 0; i < n; i++) begin
        logic [31:0] d = $urandom;
        if ($urandom % 2) d[31:24] = 8'hE0 | 8'($urandom % 8);
        sx(d, 2'd3, i == n - 1, "R7");
      end
    end
  endtask

  task automatic pkt_env(input int idx);
    logic [31:0] d = {8'hE0 | 8'(idx), 24'($urandom)};
    env_m[idx] = d;
    send(d);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R11 drain", exp_q.size(), 0);
  endtask

  task automatic check_env(input string r);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      env_idx = 3'(i);
      #1;
      check(env_data == env_m[i], r, env_data, env_m[i]);
    end
    check(status == {32'h1480_2000 >> 13, env_m[6][1:0], env_m[1][10:0]}, "R9 status",
          status, {32'h1480_2000 >> 13, env_m[6][1:0], env_m[1][10:0]});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) env_m[i] = {8'hE0 + 8'(i), 24'h0};

    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(status == 32'h1480_2000, "R1 status", status, 32'h1480_2000);
    @(negedge clk);
    rst_n = 1'b1;
    check_env("R1 env reset value");

    // R2 R3 R4 directed boundary cases
    pkt_fixed(8'h02); pkt_fixed(8'h3C); pkt_fixed(8'h6C); pkt_fixed(8'h7C); pkt_fixed(8'hE8);
    pkt_poly(1'b0, 3);   // shortest flat strip
    pkt_poly(1'b1, 4);   // shortest shaded strip
    pkt_poly(1'b1, 10);
    idle();
    drain();

    // R6 R7 transfer corners: 1x1, 3x3 (odd rounding), width field zero = 1024, junk in ignored bits
    pkt_xfer(1'b1, 32'hFE01_FC01);
    pkt_xfer(1'b1, 32'h0003_0003);
    pkt_xfer(1'b0, 32'h0004_0004);
    pkt_fixed(8'h20);
    pkt_xfer(1'b1, 32'h0001_0000);
    idle();
    drain();
    check_env("R7 env untouched by pixel data");

    // R8 R9 environment writes
    for (int i = 0; i < 8; i++) pkt_env(i);
    pkt_fixed(8'h00);
    idle();
    drain();
    check_env("R8 env write");

    // random mix under random stalls
    @(posedge clk); mode = 0;
    for (int p = 0; p < 150; p++) begin
      case ($urandom % 8)
        0, 1, 2: begin
          logic [7:0] op;
          do op = 8'($urandom);
          while (op inside {[8'h48:8'h4F], [8'h58:8'h5F], [8'h80:8'hE7]});
          pkt_fixed(op);
        end
        3: pkt_poly(1'b0, 3 + int'($urandom % 10));
        4: pkt_poly(1'b1, 4 + 2 * int'($urandom % 6));
        5: pkt_copy();
        6: pkt_xfer($urandom % 2, {7'($urandom), 9'(1 + $urandom % 4), 6'($urandom), 10'(1 + $urandom % 6)});
        default: pkt_env(int'($urandom % 8));
      endcase
      if ($urandom % 5 == 0) idle();
    end
    idle();
    drain();
    check_env("R8 env after random mix");

    // R10: complete packet ahead of a partial one stays available; partial one is held
    @(posedge clk); mode = 2;
    sx(32'h0100_0007, 2'd0, 1'b1, "R10");
    sx(32'h2800_0000, 2'd0, 1'b0, "R10");
    sx(32'h1111_1111, 2'd0, 1'b0, "R10");
    idle();
    repeat (3) @(negedge clk);
    check(out_valid && out_data == 32'h0100_0007, "R10 complete packet ahead", {out_valid, out_data}, {1'b1, 32'h0100_0007});
    @(posedge clk); mode = 1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R10 partial packet held", out_valid, 0);
    sx(32'h2222_2222, 2'd0, 1'b0, "R10");
    sx(32'h3333_3333, 2'd0, 1'b0, "R10");
    sx(32'h4444_4444, 2'd0, 1'b1, "R10");
    idle();
    check(out_valid == 1'b1, "R10 visible one cycle after last word", out_valid, 1);
    drain();

    // R11: buffer full drops in_ready
    @(posedge clk); mode = 2;
    for (int i = 0; i < DEPTH; i++) sx(32'h0000_0000 | 32'(i), 2'd0, 1'b1, "R11");
    idle();
    check(in_ready == 1'b0, "R11 in_ready low when full", in_ready, 0);
    @(posedge clk); mode = 1;
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1, "R11 in_ready back after a read", in_ready, 1);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule